// File: doc/BRIEF.md
# PME Wake Event Message Relay

This block gathers power-management event (PME) notifications from several downstream PCI Express root ports and reduces them to one level-style wake signal toward an upstream I/O hub. Each port has a status bit that a PME message sets. Software clears the bit with a write-1-to-clear access once it has handled the event. Each port also has an enable bit. The enabled status bits are ORed together, and the block tells the hub about changes in that OR level by sending assert and deassert event messages.

Outgoing messages use a one-entry valid/ready port. The block records the last level the hub accepted. It offers a message whenever the current OR level differs from that recorded level. If the level changes again before the hub accepts, the offer follows the newest level, or is withdrawn when the level returns to the recorded value. A single-cycle resume pulse, given when the system leaves suspend-to-RAM, treats the hub as having lost its state. The block then offers an assert even when the OR level is already high.

Top module: `pme_relay`

## Requirements
- R1: After reset every status bit reads 0, every enable bit reads 1, and `evt_valid_o` is 0.
- R2: A 1 on bit i of `pme_msg_i` in a cycle sets status bit i at that clock edge. Status is read at register address 0 through `reg_rdata_o`, with bit i belonging to port i.
- R3: A write to address 0 clears each status bit whose write-data bit is 1 and leaves the bits whose write-data bit is 0 unchanged. If a PME message and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: Address 1 holds the enable bits, which can be written and read back. A port whose enable bit is 0 still records status but adds nothing to the OR level. Enabling a port that has status pending raises the level.
- R5: When the OR level rises from 0 to 1, the block offers an assert message (`evt_valid_o`=1, `evt_kind_o`=1).
- R6: When the OR level falls from 1 to 0 after an assert was accepted, the block offers a deassert message (`evt_kind_o`=0).
- R7: An offered message stays offered while `evt_ready_i` is 0. If the level goes back to the last accepted value before acceptance, the offer is withdrawn.
- R8: PME messages on several ports in the same cycle produce exactly one assert message.
- R9: A one-cycle pulse on `resume_i` makes the block offer an assert in the next cycle, whatever the OR level. The last accepted level is then taken as 0.
- R10: Between resume pulses, the accepted messages alternate between assert and deassert.
- R11: No message is offered while the OR level equals the last accepted level and no resume is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pme_msg_i | input | NPORTS | One-cycle PME message indication per port |
| resume_i | input | 1 | One-cycle suspend-to-RAM exit pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register address: 0 status, 1 enable |
| reg_wdata_i | input | NPORTS | Register write data |
| reg_rdata_o | output | NPORTS | Register read data for `reg_addr_i` |
| evt_valid_o | output | 1 | Upstream message offered |
| evt_kind_o | output | 1 | 1 assert, 0 deassert |
| evt_ready_i | input | 1 | Upstream accepts the offered message |

## Verification
The bound checker watches four rules on every cycle: a PME indication sets its status bit, a status write clears exactly the bits written with 1, a resume pulse is followed by an assert offer, and accepted messages alternate. Other behaviours only show up in the bench's directed scenarios. These include the enable gating, the set-over-clear priority, the withdrawal of an offer whose level has reverted, and the single assert produced by simultaneous PME messages on several ports.

// File: rtl/pme_relay_pkg.sv
package pme_relay_pkg;
  typedef enum logic {
    EVT_DEASSERT = 1'b0,
    EVT_ASSERT   = 1'b1
  } evt_kind_e;

  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_ENABLE = 1'b1;
endpackage

// File: rtl/pme_status_bank.sv
module pme_status_bank #(
  parameter int NPORTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] pme_msg_i,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [NPORTS-1:0] wr_data_i,
  output logic [NPORTS-1:0] status_o,
  output logic [NPORTS-1:0] enable_o
);
  import pme_relay_pkg::*;

  logic              status_we;
  logic              enable_we;
  logic [NPORTS-1:0] clr_mask;
  logic [NPORTS-1:0] enable_d;
  logic [NPORTS-1:0] enable_q;
  logic [NPORTS-1:0] status_q;

  always_comb begin
    status_we = wr_en_i && (wr_addr_i == ADDR_STATUS);
    enable_we = wr_en_i && (wr_addr_i == ADDR_ENABLE);
    clr_mask  = status_we ? wr_data_i : '0;
    enable_d  = enable_we ? wr_data_i : enable_q;
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic st_d;
    logic st_ce;
    always_comb begin
      st_ce = pme_msg_i[p] | clr_mask[p];
      st_d  = pme_msg_i[p];          // a set beats a clear in the same cycle
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     status_q[p] <= 1'b0;
      else if (st_ce) status_q[p] <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         enable_q <= '1;
    else if (enable_we) enable_q <= enable_d;
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
endmodule

// File: rtl/pme_or_combiner.sv
module pme_or_combiner #(
  parameter int NPORTS = 4
) (
  input  logic [NPORTS-1:0] status_i,
  input  logic [NPORTS-1:0] enable_i,
  output logic              level_o
);
  logic [NPORTS-1:0] masked;

  always_comb begin
    masked  = status_i & enable_i;
    level_o = |masked;
  end
endmodule

// File: rtl/pme_event_tracker.sv
module pme_event_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic resume_i,
  input  logic ready_i,
  output logic valid_o,
  output logic kind_o
);
  import pme_relay_pkg::*;

  logic      sent_q, sent_d;
  logic      force_q, force_d;
  logic      accept;
  evt_kind_e kind;

  always_comb begin
    valid_o = force_q | (level_i != sent_q);
    kind    = (force_q || level_i) ? EVT_ASSERT : EVT_DEASSERT;
    accept  = valid_o & ready_i;
    sent_d  = sent_q;
    force_d = force_q;
    if (resume_i) begin
      sent_d  = 1'b0;
      force_d = 1'b1;
    end else if (accept) begin
      sent_d  = kind;
      if (kind == EVT_ASSERT) force_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent_q  <= 1'b0;
      force_q <= 1'b0;
    end else begin
      sent_q  <= sent_d;
      force_q <= force_d;
    end
  end

  assign kind_o = kind;
endmodule

// File: rtl/pme_relay.sv
module pme_relay #(
  parameter int NPORTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] pme_msg_i,
  input  logic              resume_i,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [NPORTS-1:0] reg_wdata_i,
  output logic [NPORTS-1:0] reg_rdata_o,
  output logic              evt_valid_o,
  output logic              evt_kind_o,
  input  logic              evt_ready_i
);
  import pme_relay_pkg::*;

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic [NPORTS-1:0] status_w;
  logic [NPORTS-1:0] enable_w;
  logic              level_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  pme_status_bank #(.NPORTS(NPORTS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pme_msg_i (pme_msg_i),
    .wr_en_i   (reg_we_i),
    .wr_addr_i (reg_addr_i),
    .wr_data_i (reg_wdata_i),
    .status_o  (status_w),
    .enable_o  (enable_w)
  );

  pme_or_combiner #(.NPORTS(NPORTS)) u_or (
    .status_i (status_w),
    .enable_i (enable_w),
    .level_o  (level_w)
  );

  pme_event_tracker u_trk (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .level_i  (level_w),
    .resume_i (resume_i),
    .ready_i  (evt_ready_i),
    .valid_o  (evt_valid_o),
    .kind_o   (evt_kind_o)
  );

  always_comb begin
    reg_rdata_o = (reg_addr_i == ADDR_ENABLE) ? enable_w : status_w;
  end
endmodule

// File: rtl/pme_relay_chk.sv
module pme_relay_chk #(
  parameter int NPORTS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPORTS-1:0] pme_msg_i,
  input logic              resume_i,
  input logic              reg_we_i,
  input logic              reg_addr_i,
  input logic [NPORTS-1:0] reg_wdata_i,
  input logic [NPORTS-1:0] status,
  input logic              evt_valid_o,
  input logic              evt_kind_o,
  input logic              evt_ready_i
);
  logic have_q;
  logic last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      last_q <= 1'b0;
    end else if (resume_i) begin
      have_q <= 1'b0;
    end else if (evt_valid_o && evt_ready_i) begin
      have_q <= 1'b1;
      last_q <= evt_kind_o;
    end
  end

  // R2
  pme_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pme_msg_i) |=> ((status & $past(pme_msg_i)) == $past(pme_msg_i)));

  // R3
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && !reg_addr_i && (pme_msg_i == '0))
      |=> (status == ($past(status) & ~$past(reg_wdata_i))));

  // R9
  resume_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_i |=> (evt_valid_o && evt_kind_o));

  // R10
  alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid_o && evt_ready_i && have_q && !resume_i) |-> (evt_kind_o != last_q));
endmodule

bind pme_relay pme_relay_chk #(.NPORTS(NPORTS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .pme_msg_i   (pme_msg_i),
  .resume_i    (resume_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .status      (status_w),
  .evt_valid_o (evt_valid_o),
  .evt_kind_o  (evt_kind_o),
  .evt_ready_i (evt_ready_i)
);

// File: tb/pme_relay_tb.sv
module pme_relay_tb;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pme_msg = '0;
  logic          resume = 1'b0;
  logic          we = 1'b0;
  logic          addr = 1'b0;
  logic [NP-1:0] wdata = '0;
  logic [NP-1:0] rdata;
  logic          evt_valid;
  logic          evt_kind;
  logic          evt_ready = 1'b0;

  int total = 0;
  int fails = 0;
  bit expq[$];

  always #5 clk = ~clk;

  pme_relay #(.NPORTS(NP)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pme_msg_i   (pme_msg),
    .resume_i    (resume),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .evt_valid_o (evt_valid),
    .evt_kind_o  (evt_kind),
    .evt_ready_i (evt_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic pulse_pme(input logic [NP-1:0] m);
    pme_msg = m; step(); pme_msg = '0; #1;
  endtask

  task automatic wr(input logic a, input logic [NP-1:0] d);
    we = 1'b1; addr = a; wdata = d; step(); we = 1'b0; wdata = '0; #1;
  endtask

  task automatic rd(input string req, input logic a, input logic [NP-1:0] e);
    addr = a; #1; chk(req, rdata, e);
  endtask

  task automatic take(input bit kind);
    expq.push_back(kind);
    evt_ready = 1'b1; step(); evt_ready = 1'b0; #1;
  endtask

  task automatic msg(input string req, input logic v, input logic k);
    chk({req, " valid"}, evt_valid, v);
    if (v) chk({req, " kind"}, evt_kind, k);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && evt_valid && evt_ready) begin
      if (expq.size() == 0) begin
        total++; fails++;
        $display("FAIL R10 unexpected message actual=%0d expected=none", evt_kind);
      end else begin
        bit e;
        e = expq.pop_front();
        chk("R10 accepted kind", evt_kind, e);
      end
    end
  end

  initial begin
    #2_000_000;
    total++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) step();

    // R1
    msg("R1", 1'b0, 1'b0);
    rd("R1 status", 1'b0, 4'b0000);
    rd("R1 enable", 1'b1, 4'b1111);

    // R2, R5
    pulse_pme(4'b0010);
    rd("R2 status", 1'b0, 4'b0010);
    msg("R5", 1'b1, 1'b1);
    repeat (3) step();
    msg("R7 held", 1'b1, 1'b1);
    take(1'b1);
    msg("R11 idle", 1'b0, 1'b0);

    // R3, R6
    wr(1'b0, 4'b0000);
    rd("R3 zero write", 1'b0, 4'b0010);
    msg("R11 no change", 1'b0, 1'b0);
    wr(1'b0, 4'b0010);
    rd("R3 cleared", 1'b0, 4'b0000);
    msg("R6", 1'b1, 1'b0);
    take(1'b0);
    msg("R11 after deassert", 1'b0, 1'b0);

    // R8
    pulse_pme(4'b1011);
    rd("R8 status", 1'b0, 4'b1011);
    msg("R8", 1'b1, 1'b1);
    take(1'b1);
    msg("R8 single", 1'b0, 1'b0);

    // R3 set beats clear
    pme_msg = 4'b0100; we = 1'b1; addr = 1'b0; wdata = 4'b0100;
    step();
    pme_msg = '0; we = 1'b0; wdata = '0; #1;
    rd("R3 set wins", 1'b0, 4'b1111);
    msg("R11 level steady", 1'b0, 1'b0);
    wr(1'b0, 4'b1111);
    msg("R6 all clear", 1'b1, 1'b0);
    take(1'b0);

    // R4
    wr(1'b1, 4'b1110);
    rd("R4 enable", 1'b1, 4'b1110);
    pulse_pme(4'b0001);
    rd("R4 status recorded", 1'b0, 4'b0001);
    msg("R4 gated", 1'b0, 1'b0);
    wr(1'b1, 4'b1111);
    msg("R4 enabled", 1'b1, 1'b1);
    take(1'b1);
    wr(1'b0, 4'b0001);
    msg("R6 port0", 1'b1, 1'b0);
    take(1'b0);

    // R7 withdrawal
    pulse_pme(4'b1000);
    msg("R7 offered", 1'b1, 1'b1);
    wr(1'b0, 4'b1000);
    msg("R7 withdrawn", 1'b0, 1'b0);

    // R9 with level low
    resume = 1'b1; step(); resume = 1'b0; #1;
    msg("R9 low", 1'b1, 1'b1);
    take(1'b1);
    msg("R9 follow deassert", 1'b1, 1'b0);
    take(1'b0);

    // R9 with level high
    pulse_pme(4'b0100);
    take(1'b1);
    resume = 1'b1; step(); resume = 1'b0; #1;
    msg("R9 high", 1'b1, 1'b1);
    take(1'b1);
    msg("R9 after", 1'b0, 1'b0);

    repeat (2) step();
    chk("R10 queue drained", expq.size(), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule